// File: doc/BRIEF.md
# Serial Shadowed Scratchpad Memory Slave

This block is a clocked-serial slave holding a sixteen-word by sixteen-bit RAM array. A second array of the same size sits behind it as a shadow copy, standing in for nonvolatile cells, and is modelled as ordinary registers. A host reaches the block through four pins: a chip enable, a serial clock, a serial data input and a data output with a separate output enable. Every serial pin is sampled on the block's own system clock. The block's serial clock is the chip enable ANDed with the serial clock pin, and its edges are found by comparing each sample with the one before it.

After enable goes high, the block discards zero bits until it samples a one, which starts a command. The command is eight bits in total, sent most significant bit first. The command word selects a word address and one of six operations:
- set or clear a write-enable latch;
- write one word;
- read one word;
- copy the whole RAM into the shadow;
- copy the whole shadow back into RAM.

Inside a word, a four-bit pointer steps through the bit positions and wraps from 15 to 0. The word address never advances. Two active-low pins give direct hardware access to the shadow copy and the recall copy.

Top module: `shadow_scratch_slave`

## Requirements
- R1: After synchronous reset, the output enable is low, the write-enable latch is clear, and both arrays hold zero.
- R2: While enable is high and no command is in progress, a rising edge of the gated clock that samples a 0 on the data input is ignored. The first sampled 1 is the start bit of a command.
- R3: A command is eight bits, sent most significant bit first, in this order: start bit, four word-address bits (most significant first), three opcode bits. The opcodes are: 000 write-disable, 001 store, 010 reserved, 011 write, 100 write-enable, 101 recall, 11x read.
- R4: After a write command, each further rising edge writes the sampled input into the addressed word at bit position 0, then 1, and so on up to 15. The pointer then wraps, so a seventeenth data edge overwrites bit 0 of the same word.
- R5: For a read command, the output enable rises on the first falling edge of the gated clock after the eighth command bit, and bit 0 of the addressed word is presented. Each later falling edge advances to the next bit, wrapping from 15 to 0.
- R6: Sampling enable low forces the output enable low on the next clock. It also ends any command and restarts the bit counting for the next command.
- R7: The write-enable opcode sets the latch and the write-disable opcode clears it. A write command or a store command issued while the latch is clear changes nothing.
- R8: A store command with the latch set copies the whole RAM into the shadow in one clock. A recall command copies the whole shadow into RAM in one clock and clears the latch.
- R9: A low hardware-store pin copies RAM into the shadow regardless of the latch. A low hardware-recall pin copies the shadow into RAM and clears the latch. A hardware recall takes priority over a serial bit write in the same clock, and a hardware store captures the RAM as it was before that clock's write.
- R10: Raising enable while the serial clock pin is already high counts as a rising edge and samples the data input.
- R11: After a single-byte command, further clocks are ignored until enable drops. A reserved opcode changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable, active high |
| sk | input | 1 | Serial clock pin |
| sdi | input | 1 | Serial data input |
| store_n | input | 1 | Hardware store pin, active low |
| recall_n | input | 1 | Hardware recall pin, active low |
| sdo | output | 1 | Serial data output; valid only while sdo_oe is high |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |

## Verification
The hardware pins act on the whole array in the same system clock in which a serial data bit may be landing in RAM. The bench raises the serial clock and pulls a hardware pin low in the same cycle, on the sixteenth data edge of a write. For the store case, the expected outcome is that the shadow holds the word without that final bit while RAM holds it; for the recall case, the expected outcome is that RAM reverts to the shadow and the bit is lost. Both outcomes are read back over the serial interface and compared with fixed values. A cycle model also compares the outputs on every clock.

// File: rtl/ssm_pkg.sv
// Shared types for the serial shadowed scratchpad slave.
// Assumes opcode field is three bits, placed last in the command word.
package ssm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, // waiting for a start bit
        ST_CMD,  // collecting command bits
        ST_WR,   // data phase of a write
        ST_RD,   // data phase of a read
        ST_DONE  // command finished, clocks ignored until enable drops
    } ssm_state_e;

    localparam logic [2:0] OP_WRDI  = 3'b000;
    localparam logic [2:0] OP_STORE = 3'b001;
    localparam logic [2:0] OP_WRITE = 3'b011;
    localparam logic [2:0] OP_WREN  = 3'b100;
    localparam logic [2:0] OP_RCL   = 3'b101;
endpackage

// File: rtl/ssm_sclk_edge.sv
// Gated serial-clock edge detector.
// Gates the serial clock with chip enable, so an enable rise while the
// clock pin is high yields a rising edge. Inputs assumed synchronous to clk.
module ssm_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sk,
    output logic rise,
    output logic fall
);
    logic gclk;
    logic gclk_q;

    assign gclk = ce & sk;
    assign rise = gclk & ~gclk_q;
    assign fall = ~gclk & gclk_q;

    // Remember the previous gated-clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) gclk_q <= 1'b0;
        else        gclk_q <= gclk;
    end
endmodule

// File: rtl/ssm_ctrl.sv
// Command sequencer: start-bit hunt, command shift, decode, bit pointer,
// write-enable latch and output-enable. Assumes WIDTH is a power of two
// so the bit pointer wraps by overflow.
module ssm_ctrl
    import ssm_pkg::*;
#(
    parameter int AW = 4,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          rise,
    input  logic          fall,
    input  logic          sdi,
    input  logic          hw_recall,
    output logic          wr_en,
    output logic [AW-1:0] word_sel,
    output logic [PW-1:0] bit_sel,
    output logic          sto_req,
    output logic          rcl_req,
    output logic          oe,
    output logic          wel
);
    localparam int CMD_BITS = 1 + AW + 3;
    localparam int SHW      = CMD_BITS - 2;
    localparam int CW       = $clog2(CMD_BITS);
    localparam logic [CW-1:0] LAST = CW'(CMD_BITS - 1);

    ssm_state_e     st;
    logic [CW-1:0]  cnt;
    logic [SHW-1:0] shreg;
    logic [AW-1:0]  addr;
    logic [PW-1:0]  ptr;
    logic [AW+2:0]  cmd_word;
    logic [2:0]     op;
    logic           dec;
    ssm_state_e     dec_next;

    assign cmd_word = {shreg, sdi};
    assign op       = cmd_word[2:0];
    assign dec      = ce && rise && (st == ST_CMD) && (cnt == LAST);
    assign wr_en    = ce && rise && (st == ST_WR);
    assign sto_req  = dec && (op == OP_STORE) && wel;
    assign rcl_req  = dec && (op == OP_RCL);
    assign word_sel = addr;
    assign bit_sel  = ptr;

    // Pick the state that follows a decoded command.
    always_comb begin
        if (op[2:1] == 2'b11)                 dec_next = ST_RD;
        else if ((op == OP_WRITE) && wel)     dec_next = ST_WR;
        else                                  dec_next = ST_DONE;
    end

    // Sequence the serial protocol and hold the latch and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            addr  <= '0;
            ptr   <= '0;
            oe    <= 1'b0;
            wel   <= 1'b0;
        end else begin
            if (!ce) begin
                st  <= ST_IDLE;
                cnt <= '0;
                ptr <= '0;
                oe  <= 1'b0;
            end else if (rise) begin
                case (st)
                    ST_IDLE: if (sdi) begin
                        st  <= ST_CMD;
                        cnt <= CW'(1);
                    end
                    ST_CMD: if (cnt == LAST) begin
                        addr <= cmd_word[AW+2:3];
                        ptr  <= '0;
                        st   <= dec_next;
                        if (op == OP_WREN) wel <= 1'b1;
                        if (op == OP_WRDI) wel <= 1'b0;
                    end else begin
                        shreg <= {shreg[SHW-2:0], sdi};
                        cnt   <= cnt + CW'(1);
                    end
                    ST_WR:   ptr <= ptr + PW'(1);
                    default: ;
                endcase
            end else if (fall && (st == ST_RD)) begin
                if (oe) ptr <= ptr + PW'(1);
                oe <= 1'b1;
            end
            if (hw_recall || rcl_req) wel <= 1'b0;
        end
    end
endmodule

// File: rtl/ssm_array.sv
// RAM array with a bit-for-bit shadow array.
// Whole-array copies take one clock; a recall overrides a same-cycle bit
// write; a store always captures RAM as it stood before this clock.
module ssm_array #(
    parameter int WORDS = 16,
    parameter int WIDTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          word_sel,
    input  logic [PW-1:0]          bit_sel,
    input  logic                   wr_data,
    input  logic                   to_shadow,
    input  logic                   to_ram,
    output logic                   rd_data,
    output logic [WORDS*WIDTH-1:0] ram_flat,
    output logic [WORDS*WIDTH-1:0] shadow_flat
);
    logic [WORDS-1:0][WIDTH-1:0] ram;
    logic [WORDS-1:0][WIDTH-1:0] shadow;

    assign rd_data     = ram[word_sel][bit_sel];
    assign ram_flat    = ram;
    assign shadow_flat = shadow;

    // Update the arrays: whole-array copies and single-bit writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram    <= '0;
            shadow <= '0;
        end else begin
            if (to_shadow) shadow <= ram;
            if (to_ram)     ram <= shadow;
            else if (wr_en) ram[word_sel][bit_sel] <= wr_data;
        end
    end
endmodule

// File: rtl/shadow_scratch_slave.sv
// Top level of the serial shadowed scratchpad slave.
// Joins edge detection, command control and the dual array; hardware
// pins are active low and level sensitive, sampled on clk.
module shadow_scratch_slave #(
    parameter int WORDS = 16,
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sk,
    input  logic sdi,
    input  logic store_n,
    input  logic recall_n,
    output logic sdo,
    output logic sdo_oe
);
    localparam int AW   = $clog2(WORDS);
    localparam int PW   = $clog2(WIDTH);
    localparam int BITS = WORDS * WIDTH;

    logic          rise, fall;
    logic          wr_en, sto_req, rcl_req, oe, wel, rd_data;
    logic [AW-1:0] word_sel;
    logic [PW-1:0] bit_sel;
    logic [BITS-1:0] ram_flat, shadow_flat;

    ssm_sclk_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sk(sk), .rise(rise), .fall(fall)
    );

    ssm_ctrl #(.AW(AW), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce(ce), .rise(rise), .fall(fall),
        .sdi(sdi), .hw_recall(!recall_n), .wr_en(wr_en),
        .word_sel(word_sel), .bit_sel(bit_sel), .sto_req(sto_req),
        .rcl_req(rcl_req), .oe(oe), .wel(wel)
    );

    ssm_array #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW), .PW(PW)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_sel(word_sel),
        .bit_sel(bit_sel), .wr_data(sdi), .to_shadow(sto_req || !store_n),
        .to_ram(rcl_req || !recall_n), .rd_data(rd_data),
        .ram_flat(ram_flat), .shadow_flat(shadow_flat)
    );

    assign sdo_oe = oe;
    assign sdo    = oe ? rd_data : 1'b0;
endmodule

// File: rtl/ssm_checker.sv
// Property checker for the serial shadowed scratchpad slave, bound to the top.
module ssm_checker #(
    parameter int BITS = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ce,
    input logic            sk,
    input logic            store_n,
    input logic            recall_n,
    input logic            sdo_oe,
    input logic            wel,
    input logic [BITS-1:0] ram_flat,
    input logic [BITS-1:0] shadow_flat
);
    AST_CE_LOW_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> !sdo_oe); // R6
    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (!$past(ce && sk) && $past(ce && sk, 2))); // R5
    AST_HW_STORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        !store_n |=> (shadow_flat == $past(ram_flat))); // R9
    AST_HW_RECALL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_n |=> (ram_flat == $past(shadow_flat))); // R9
    AST_RECALL_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !recall_n |=> !wel); // R7
endmodule

bind shadow_scratch_slave ssm_checker #(.BITS(WORDS * WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sk(sk), .store_n(store_n),
    .recall_n(recall_n), .sdo_oe(sdo_oe), .wel(wel),
    .ram_flat(ram_flat), .shadow_flat(shadow_flat)
);

// File: tb/tb_shadow_scratch_slave.sv
`timescale 1ns/1ps
module tb_shadow_scratch_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, sk = 1'b0, sdi = 1'b0, store_n = 1'b1, recall_n = 1'b1;
    logic sdo, sdo_oe;
    int   n_tests = 0, n_fail = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    shadow_scratch_slave dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sk(sk), .sdi(sdi),
        .store_n(store_n), .recall_n(recall_n), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ram [16];
    logic [15:0] m_shd [16];
    int  m_st = 0, m_cnt = 0, m_bits = 0, m_addr = 0, m_ptr = 0;
    bit  m_oe = 0, m_wel = 0, m_gq = 0;

    always @(posedge clk) begin : model
        logic [15:0] old_ram [16];
        logic [15:0] old_shd [16];
        bit g, rise, fall, old_wel;
        int full, op;
        if (!rst_n) begin
            foreach (m_ram[i]) begin m_ram[i] = 0; m_shd[i] = 0; end
            m_st = 0; m_cnt = 0; m_bits = 0; m_addr = 0; m_ptr = 0;
            m_oe = 0; m_wel = 0; m_gq = 0;
        end else begin
            g = ce && sk; rise = g && !m_gq; fall = !g && m_gq; m_gq = g;
            old_ram = m_ram; old_shd = m_shd; old_wel = m_wel;
            if (!ce) begin
                m_st = 0; m_cnt = 0; m_ptr = 0; m_oe = 0;
            end else if (rise) begin
                if (m_st == 0 && sdi) begin
                    m_st = 1; m_cnt = 1; m_bits = 0;
                end else if (m_st == 1) begin
                    if (m_cnt < 7) begin
                        m_bits = m_bits * 2 + int'(sdi); m_cnt++;
                    end else begin
                        full = m_bits * 2 + int'(sdi);
                        m_addr = (full / 8) % 16; op = full % 8; m_ptr = 0;
                        m_st = 4;
                        case (op)
                            0: m_wel = 0;
                            4: m_wel = 1;
                            1: if (old_wel) m_shd = old_ram;
                            5: begin m_ram = old_shd; m_wel = 0; end
                            3: if (old_wel) m_st = 2;
                            6, 7: m_st = 3;
                            default: ;
                        endcase
                    end
                end else if (m_st == 2) begin
                    m_ram[m_addr][m_ptr] = sdi;
                    m_ptr = (m_ptr + 1) % 16;
                end
            end else if (fall && m_st == 3) begin
                if (m_oe) m_ptr = (m_ptr + 1) % 16;
                m_oe = 1;
            end
            if (!store_n) m_shd = old_ram;
            if (!recall_n) begin m_ram = old_shd; m_wel = 0; end
        end
    end

    // Compare outputs with the model each cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_tests++;
            if (sdo_oe !== m_oe) begin
                n_fail++;
                $display("FAIL R6 output enable: actual %0b expected %0b at %0t", sdo_oe, m_oe, $time);
            end
            if (m_oe) begin
                n_tests++;
                if (sdo !== m_ram[m_addr][m_ptr]) begin
                    n_fail++;
                    $display("FAIL R5 read bit: actual %0b expected %0b at %0t", sdo, m_ram[m_addr][m_ptr], $time);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic frame_open();
        ce = 0; sk = 0; sdi = 0; wait_n(2); ce = 1; wait_n(1);
    endtask

    task automatic frame_close();
        sk = 0; wait_n(1); ce = 0; sdi = 0; wait_n(2);
    endtask

    task automatic send_bit(input logic b);
        sk = 0; sdi = b; wait_n(2); sk = 1; wait_n(2);
    endtask

    task automatic send_bit_hw(input logic b, input bit st, input bit rc);
        sk = 0; sdi = b; wait_n(2);
        sk = 1; store_n = !st; recall_n = !rc; wait_n(1);
        store_n = 1; recall_n = 1; wait_n(1);
    endtask

    task automatic send_cmd(input logic [3:0] a, input logic [2:0] op);
        logic [7:0] w;
        w = {1'b1, a, op};
        for (int i = 7; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic single(input logic [2:0] op);
        frame_open(); send_cmd(4'd0, op); frame_close();
    endtask

    task automatic write_word(input logic [3:0] a, input logic [15:0] d);
        frame_open(); send_cmd(a, 3'b011);
        for (int i = 0; i < 16; i++) send_bit(d[i]);
        frame_close();
    endtask

    task automatic read_word(input logic [3:0] a, input int n, output logic [31:0] v);
        v = '0;
        frame_open(); send_cmd(a, 3'b110);
        for (int i = 0; i < n; i++) begin
            sk = 0; wait_n(2); v[i] = sdo; sk = 1; wait_n(2);
        end
        frame_close();
    endtask

    task automatic pulse_pin(input bit st, input bit rc);
        store_n = !st; recall_n = !rc; wait_n(1); store_n = 1; recall_n = 1; wait_n(1);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        logic [31:0] v;
        wait_n(3); rst_n = 1; wait_n(1);
        check("R1 output enable after reset", {31'b0, sdo_oe}, 0);

        // R7: write without the latch set is ignored; R1 latch clear, array zero
        write_word(4'd3, 16'hA5A5);
        read_word(4'd3, 16, v); check("R1/R7 write ignored without latch", v, 32'h0);

        // R2/R3/R4: leading zeros then write with latch set
        single(3'b100);
        frame_open(); send_bit(0); send_bit(0); send_bit(0);
        send_cmd(4'd3, 3'b011);
        for (int i = 0; i < 16; i++) send_bit(v[i] | 1'b0 ? 1'b0 : 1'b0 | 16'h1234 >> i);
        frame_close();
        read_word(4'd3, 16, v); check("R2/R3/R4 write then read", v, 32'h1234);

        // R4: seventeenth data edge overwrites bit 0
        frame_open(); send_cmd(4'd5, 3'b011);
        for (int i = 0; i < 16; i++) send_bit(16'h00F0 >> i);
        send_bit(1); frame_close();
        read_word(4'd5, 16, v); check("R4 pointer wrap overwrites bit 0", v, 32'h00F1);

        // R5: read wraps after bit 15
        read_word(4'd3, 17, v); check("R5 read wraps to bit 0", v, 32'h0_1234);

        // R8: store, overwrite, recall restores and clears the latch
        single(3'b001);
        write_word(4'd3, 16'hFFFF);
        read_word(4'd3, 16, v); check("R4 overwrite before recall", v, 32'hFFFF);
        single(3'b101);
        read_word(4'd3, 16, v); check("R8 recall restores", v, 32'h1234);
        write_word(4'd3, 16'h0F0F);
        read_word(4'd3, 16, v); check("R8/R7 latch cleared by recall", v, 32'h1234);

        // R7: store ignored after write-disable
        single(3'b100); write_word(4'd3, 16'h5555); single(3'b000);
        single(3'b001); single(3'b101);
        read_word(4'd3, 16, v); check("R7 store ignored after write-disable", v, 32'h1234);

        // R9: hardware store ignores the latch
        single(3'b100); write_word(4'd7, 16'hBEEF); single(3'b000);
        pulse_pin(1, 0);
        single(3'b100); write_word(4'd7, 16'h0000);
        pulse_pin(0, 1);
        read_word(4'd7, 16, v); check("R9 hardware store then recall", v, 32'hBEEF);

        // R6: abort mid-write, then restart counting
        single(3'b100);
        frame_open(); send_cmd(4'd9, 3'b011);
        for (int i = 0; i < 5; i++) send_bit(1);
        frame_close();
        read_word(4'd9, 16, v); check("R6 aborted write keeps bits", v, 32'h001F);
        write_word(4'd9, 16'h8000);
        read_word(4'd9, 16, v); check("R6 counter restarts after abort", v, 32'h8000);
        frame_open(); send_cmd(4'd9, 3'b110);
        for (int i = 0; i < 4; i++) begin sk = 0; wait_n(2); sk = 1; wait_n(2); end
        ce = 0; wait_n(2);
        check("R6 output enable drops with enable", {31'b0, sdo_oe}, 0);

        // R11: trailing clocks after single-byte command and reserved opcode
        frame_open(); send_cmd(4'd0, 3'b000);
        for (int i = 0; i < 8; i++) send_bit(1);
        frame_close();
        write_word(4'd9, 16'h0000);
        read_word(4'd9, 16, v); check("R11/R7 trailing clocks ignored", v, 32'h8000);
        single(3'b100);
        frame_open(); send_cmd(4'd9, 3'b010);
        for (int i = 0; i < 16; i++) send_bit(0);
        frame_close();
        read_word(4'd9, 16, v); check("R11 reserved opcode no effect", v, 32'h8000);

        // R10: enable rises while serial clock is high
        single(3'b100);
        ce = 0; sk = 1; sdi = 1; wait_n(2); ce = 1; wait_n(2);
        begin
            logic [6:0] rest;
            rest = {4'd11, 3'b011};
            for (int i = 6; i >= 0; i--) send_bit(rest[i]);
        end
        for (int i = 0; i < 16; i++) send_bit(16'h0C3A >> i);
        frame_close();
        read_word(4'd11, 16, v); check("R10 enable-rise counts as edge", v, 32'h0C3A);

        // R9: hardware store in the same cycle as the last data edge
        single(3'b100);
        frame_open(); send_cmd(4'd13, 3'b011);
        for (int i = 0; i < 15; i++) send_bit(1);
        send_bit_hw(1, 1, 0); frame_close();
        read_word(4'd13, 16, v); check("R9 ram keeps last bit", v, 32'hFFFF);
        pulse_pin(0, 1);
        read_word(4'd13, 16, v); check("R9 store captured pre-write ram", v, 32'h7FFF);

        // R9: hardware recall overrides the same-cycle bit write
        single(3'b100);
        frame_open(); send_cmd(4'd12, 3'b011);
        for (int i = 0; i < 15; i++) send_bit(1);
        send_bit_hw(1, 0, 1); frame_close();
        read_word(4'd12, 16, v); check("R9 recall overrides write", v, 32'h0000);
        write_word(4'd12, 16'h00FF);
        read_word(4'd12, 16, v); check("R9/R7 latch cleared by hardware recall", v, 32'h0000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule